// File: doc/BRIEF.md
# Clock Control Register with Switching Interlocks

This block is the control register of a small clock generator. One 8-bit write port sets a PLL enable bit, a PLL multiplication ratio, a system clock source select and a peripheral clock select. The write rules between these bits are enforced in hardware. Software cannot move the system clock onto the PLL while the PLL is off, before it has settled, or during a ratio change. The peripheral select can be changed only once after reset. A read port returns the current register image.

A settle counter runs on the input clock. Its length is set by a parameter, which should equal 2 ms of input-clock cycles. The counter restarts at reset and on every ratio change, and it raises a ready flag when it expires. The stored select bit drives a glitch-free switch between the raw input clock and the PLL output clock. The switch hands over through a synchroniser in each clock domain, so neither clock is ever cut short.

Top module: `clk_ctrl_reg`

## Requirements
- R1: After reset, all register fields read 0 (rd_data_o = 0x00), the PLL is disabled, settle_ready_o is 0 and the system clock comes from the input clock (src_pll_o = 0).
- R2: Register image layout is fixed:
  - bit 1 is the PLL enable;
  - bits 3:2 are the ratio;
  - bit 5 is the system clock select;
  - bits 7:6 are the peripheral select;
  - bits 0 and 4 always read 0.
  - The field outputs match the image.
- R3: A write with bit 1 = 0 clears the PLL enable, and also clears the system clock select in that same write, whatever bit 5 of the written data holds.
- R4: While the stored PLL enable is 0, writes to the select bit are ignored and the bit reads 0. This includes a write that sets the enable and the select together.
- R5: The select bit can go from 0 to 1 only when settle_ready_o and pll_lock_i are both 1 in the cycle of the write; otherwise the attempt is ignored.
- R6: Ratio codes are 01 = x2, 10 = x3, 11 = x4. A write carrying ratio code 00 leaves the stored ratio unchanged.
- R7: A write that changes the ratio also clears the select bit and restarts the settle counter. settle_ready_o then rises SETTLE_CYCLES clock edges after that write.
- R8: After reset, the first write that carries a peripheral select value different from the stored one is accepted. Every later change to that field is ignored.
- R9: settle_ready_o rises exactly SETTLE_CYCLES rising clock edges after reset is released.
- R10: After the select bit is set, src_pll_o goes to 1 within a few clock cycles and sys_clk_o then follows pll_clk_i. After the bit is cleared, the switch returns to the input clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Raw input clock; clocks the register and the settle counter |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pll_clk_i | input | 1 | PLL output clock |
| pll_lock_i | input | 1 | PLL lock indication |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read image |
| pll_en_o | output | 1 | PLL enable |
| pll_ratio_o | output | 2 | PLL ratio code |
| sys_sel_o | output | 1 | Stored system clock select |
| periph_sel_o | output | 2 | Peripheral clock select |
| settle_ready_o | output | 1 | Settle interval has elapsed |
| src_pll_o | output | 1 | Clock switch is currently passing the PLL clock |
| sys_clk_o | output | 1 | Glitch-free system clock |

## Verification
The bound checker tests a set of invariants on every cycle:
- the select bit never stands without the enable;
- clearing the enable drops the select on the next edge;
- the select rises only after a cycle with both ready and lock;
- a legal ratio never falls back to 00;
- a ratio change always leaves ready and the select low;
- the peripheral field stays frozen after its first change;
- the two reserved bits stay at 0.

Only the directed scenarios can show the rest:
- the exact cycle counts of the settle interval;
- that rejected writes leave the whole image intact;
- that the output clock actually follows the PLL clock after the handover and returns to the input clock after the select is cleared.

// File: rtl/clk_ctrl_pkg.sv
package clk_ctrl_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned EN_BIT   = 1;
  localparam int unsigned RAT_LO   = 2;
  localparam int unsigned RAT_HI   = 3;
  localparam int unsigned SEL_BIT  = 5;
  localparam int unsigned PER_LO   = 6;
  localparam int unsigned PER_HI   = 7;

  typedef enum logic [1:0] {
    RATIO_OFF = 2'b00,
    RATIO_X2  = 2'b01,
    RATIO_X3  = 2'b10,
    RATIO_X4  = 2'b11
  } ratio_e;
endpackage

// File: rtl/clk_ctrl_settle.sv
module clk_ctrl_settle #(
  parameter int unsigned SETTLE_CYCLES = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (restart_i)     cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == LIMIT);
endmodule

// File: rtl/clk_ctrl_glitch_mux.sv
module clk_ctrl_glitch_mux #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic rst_ni,
  input  logic sel_b_i,
  output logic on_b_o,
  output logic clk_o
);
  logic [SYNC_STAGES-1:0] a_q, b_q;
  logic a_req, b_req;

  // each side enables only once the other side has released
  assign a_req = ~sel_b_i & ~b_q[SYNC_STAGES-1];
  assign b_req =  sel_b_i & ~a_q[SYNC_STAGES-1];

  always_ff @(negedge clk_a_i or negedge rst_ni) begin
    if (!rst_ni) a_q <= '1;
    else         a_q <= {a_q[SYNC_STAGES-2:0], a_req};
  end

  always_ff @(negedge clk_b_i or negedge rst_ni) begin
    if (!rst_ni) b_q <= '0;
    else         b_q <= {b_q[SYNC_STAGES-2:0], b_req};
  end

  assign on_b_o = b_q[SYNC_STAGES-1];
  assign clk_o  = (clk_a_i & a_q[SYNC_STAGES-1]) | (clk_b_i & b_q[SYNC_STAGES-1]);
endmodule

// File: rtl/clk_ctrl_reg.sv
module clk_ctrl_reg
  import clk_ctrl_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 20000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pll_clk_i,
  input  logic             pll_lock_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             pll_en_o,
  output logic [1:0]       pll_ratio_o,
  output logic             sys_sel_o,
  output logic [1:0]       periph_sel_o,
  output logic             settle_ready_o,
  output logic             src_pll_o,
  output logic             sys_clk_o
);
  logic       en_q, en_d;
  logic       sel_q, sel_d;
  logic [1:0] ratio_q, ratio_d;
  logic [1:0] per_q, per_d;
  logic       per_lock_q, per_lock_d;
  logic [1:0] w_ratio, w_per;
  logic       ratio_chg, per_chg, ready;

  assign w_ratio = wr_data_i[RAT_HI:RAT_LO];
  assign w_per   = wr_data_i[PER_HI:PER_LO];

  always_comb begin
    ratio_chg = wr_en_i && (w_ratio != RATIO_OFF) && (w_ratio != ratio_q);
    per_chg   = wr_en_i && !per_lock_q && (w_per != per_q);
    ratio_d   = ratio_chg ? w_ratio : ratio_q;
    per_d     = per_chg ? w_per : per_q;
    per_lock_d = per_lock_q | per_chg;
    en_d      = wr_en_i ? wr_data_i[EN_BIT] : en_q;
    sel_d     = sel_q;
    if (wr_en_i) begin
      if (!wr_data_i[EN_BIT] || ratio_chg || !wr_data_i[SEL_BIT]) sel_d = 1'b0;
      else if (!sel_q && en_q && ready && pll_lock_i)            sel_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      sel_q      <= 1'b0;
      ratio_q    <= RATIO_OFF;
      per_q      <= 2'b00;
      per_lock_q <= 1'b0;
    end else begin
      en_q       <= en_d;
      sel_q      <= sel_d;
      ratio_q    <= ratio_d;
      per_q      <= per_d;
      per_lock_q <= per_lock_d;
    end
  end

  clk_ctrl_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (ratio_chg),
    .ready_o   (ready)
  );

  clk_ctrl_glitch_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .clk_a_i (clk_i),
    .clk_b_i (pll_clk_i),
    .rst_ni  (rst_ni),
    .sel_b_i (sel_q),
    .on_b_o  (src_pll_o),
    .clk_o   (sys_clk_o)
  );

  always_comb begin
    rd_data_o                  = '0;
    rd_data_o[EN_BIT]          = en_q;
    rd_data_o[RAT_HI:RAT_LO]   = ratio_q;
    rd_data_o[SEL_BIT]         = sel_q;
    rd_data_o[PER_HI:PER_LO]   = per_q;
  end

  assign pll_en_o       = en_q;
  assign pll_ratio_o    = ratio_q;
  assign sys_sel_o      = sel_q;
  assign periph_sel_o   = per_q;
  assign settle_ready_o = ready;
endmodule

// File: rtl/clk_ctrl_reg_chk.sv
module clk_ctrl_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pll_lock_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       pll_en_o,
  input logic [1:0] pll_ratio_o,
  input logic       sys_sel_o,
  input logic [1:0] periph_sel_o,
  input logic       settle_ready_o
);
  logic [1:0] per_prev_q;
  logic       per_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_prev_q <= 2'b00;
      per_seen_q <= 1'b0;
    end else begin
      per_prev_q <= periph_sel_o;
      per_seen_q <= per_seen_q | (periph_sel_o != per_prev_q);
    end
  end

  p_sel_needs_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_sel_o |-> pll_en_o);

  p_en_clear_drops_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[1]) |=> !sys_sel_o);

  p_sel_rise_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_sel_o) |-> $past(settle_ready_o && pll_lock_i));

  p_ratio_never_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_ratio_o != 2'b00) |=> (pll_ratio_o != 2'b00));

  p_ratio_change_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pll_ratio_o) |-> (!settle_ready_o && !sys_sel_o));

  p_periph_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_seen_q |-> (periph_sel_o == per_prev_q));

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[0] == 1'b0) && (rd_data_o[4] == 1'b0));
endmodule

bind clk_ctrl_reg clk_ctrl_reg_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pll_lock_i     (pll_lock_i),
  .wr_en_i        (wr_en_i),
  .wr_data_i      (wr_data_i),
  .rd_data_o      (rd_data_o),
  .pll_en_o       (pll_en_o),
  .pll_ratio_o    (pll_ratio_o),
  .sys_sel_o      (sys_sel_o),
  .periph_sel_o   (periph_sel_o),
  .settle_ready_o (settle_ready_o)
);

// File: tb/clk_ctrl_reg_test.sv
module clk_ctrl_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int PLL_PERIOD = 6;
  localparam int SETTLE     = 16;

  logic       clk = 1'b0, pll_clk = 1'b0, rst_n = 1'b0;
  logic       lock = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       en_o, sel_o, ready_o, src_pll, sys_clk;
  logic [1:0] ratio_o, per_o;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  initial begin
    #1;
    forever #(PLL_PERIOD/2) pll_clk = ~pll_clk;
  end

  clk_ctrl_reg #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pll_clk_i(pll_clk), .pll_lock_i(lock),
    .wr_en_i(wr_en), .wr_data_i(wdata), .rd_data_o(rdata), .pll_en_o(en_o),
    .pll_ratio_o(ratio_o), .sys_sel_o(sel_o), .periph_sel_o(per_o),
    .settle_ready_o(ready_o), .src_pll_o(src_pll), .sys_clk_o(sys_clk)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 image", rdata, 8'h00);
    chk("R1 en", {7'b0, en_o}, 8'h0);
    chk("R1 ready", {7'b0, ready_o}, 8'h0);
    chk("R1 src", {7'b0, src_pll}, 8'h0);
  endtask

  task automatic t_settle_after_reset;
    repeat (SETTLE - 1) @(negedge clk);
    chk("R9 not yet ready", {7'b0, ready_o}, 8'h0);
    @(negedge clk);
    chk("R9 ready", {7'b0, ready_o}, 8'h1);
  endtask

  task automatic t_sel_blocked_when_off;
    lock = 1'b1;
    wr(8'h20);
    chk("R4 sel alone", rdata, 8'h00);
    wr(8'h22);
    chk("R4 en+sel together", rdata, 8'h02);
    chk("R2 en port", {7'b0, en_o}, 8'h1);
  endtask

  task automatic t_ratio_reject;
    wr(8'h06);
    chk("R6 ratio x2", rdata, 8'h06);
    chk("R7 restart", {7'b0, ready_o}, 8'h0);
    wr(8'h02);
    chk("R6 code 00 rejected", rdata, 8'h06);
    chk("R2 ratio port", {6'b0, ratio_o}, 8'h01);
  endtask

  task automatic t_sel_gate;
    wr(8'h26);
    chk("R5 not ready", rdata, 8'h06);
    repeat (SETTLE) @(negedge clk);
    lock = 1'b0;
    wr(8'h26);
    chk("R5 no lock", rdata, 8'h06);
    lock = 1'b1;
    wr(8'h26);
    chk("R5 set", rdata, 8'h26);
    chk("R2 sel port", {7'b0, sel_o}, 8'h1);
  endtask

  task automatic t_switch_to_pll;
    repeat (10) @(negedge clk);
    chk("R10 on pll", {7'b0, src_pll}, 8'h1);
    for (int i = 0; i < 4; i++) begin
      @(posedge pll_clk); #1;
      chk("R10 follows pll high", {7'b0, sys_clk}, 8'h1);
      @(negedge pll_clk); #1;
      chk("R10 follows pll low", {7'b0, sys_clk}, 8'h0);
    end
  endtask

  task automatic t_ratio_change;
    wr(8'h2A);
    chk("R7 sel cleared", rdata, 8'h0A);
    repeat (SETTLE - 1) @(negedge clk);
    chk("R7 not yet ready", {7'b0, ready_o}, 8'h0);
    @(negedge clk);
    chk("R7 ready", {7'b0, ready_o}, 8'h1);
  endtask

  task automatic t_disable_clears;
    wr(8'h2A);
    chk("R5 reselect", rdata, 8'h2A);
    wr(8'h28);
    chk("R3 forced clear", rdata, 8'h08);
    repeat (10) @(negedge clk);
    chk("R10 back on input", {7'b0, src_pll}, 8'h0);
  endtask

  task automatic t_periph_once;
    wr(8'h48);
    chk("R8 first change", rdata, 8'h48);
    wr(8'hC8);
    chk("R8 second ignored", rdata, 8'h48);
    wr(8'h08);
    chk("R8 third ignored", rdata, 8'h48);
    chk("R2 periph port", {6'b0, per_o}, 8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_settle_after_reset;
    t_sel_blocked_when_off;
    t_ratio_reject;
    t_sel_gate;
    t_switch_to_pll;
    t_ratio_change;
    t_disable_clears;
    t_periph_once;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule